// File: doc/BRIEF.md
# Synchronous Sync Character Hunter

This block is the front end of a synchronous serial receiver. It takes one data bit per pulse of a receive clock enable and starts in hunt mode. In hunt mode it slides a window as wide as the configured word length over the incoming stream, one bit at a time. It compares that window against the low bits of a programmable sync character. There is no word framing while it hunts.

When the window matches, the block moves to framing mode and raises a one-cycle sync interrupt pulse. It then cuts the stream into back-to-back words. The word that completed the match is never handed on.

Each framed word goes to the receive buffer interface as a strobe, together with the word and a suppress flag. The suppress flag is raised when sync stripping is enabled and the word equals the sync character. A match flag follows every word that is actually delivered. A host can force either mode through a write strobe. Turning the receiver off sends the block back to hunting and clears its flags.

Top module: `sync_hunter`

## Requirements
- R1: After reset, found, sync_irq, word_stb, word_sup and match_flag are all 0.
- R2: While found is 0, each bit_en pulse shifts rx_bit into a window of L = 5 + word_len bits. The first received bit ends in bit 0 of the window. When at least L bits have arrived since hunting began and the window equals sync_char[L-1:0], found goes to 1 and sync_irq is 1 for exactly the cycle after that edge. Bits of sync_char at positions L and above are ignored.
- R3: While hunting, a window that differs from the sync character leaves found at 0.
- R4: The word that ended the hunt produces no word_stb.
- R5: While found is 1, every L-th bit_en pulse gives a one-cycle word_stb. word_data then holds the last L bits, with the first one in bit 0 and zeros above. The next word starts with the following bit, with no gap.
- R6: A delivered word (word_stb with word_sup 0) sets match_flag to 1 if it equals sync_char[L-1:0] and to 0 otherwise. match_flag keeps its value in all other cycles while rx_enable is 1.
- R7: With strip_en at 1, a word equal to sync_char[L-1:0] gives word_stb with word_sup at 1 and leaves match_flag unchanged. word_sup is never 1 without word_stb.
- R8: A cycle with fs_wr at 1 loads found with fs_wr_val and restarts the bit count and window from empty. A bit_en pulse in the same cycle is discarded.
- R9: While rx_enable is 0, found and match_flag go to 0 and no pulses are produced. Bits that arrive while disabled are ignored, and hunting restarts from an empty window.
- R10: A match needs at least L bits since hunting (re)started, even when the sync character is all zeros.
- R11: rx_bit has no effect in cycles where bit_en is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_enable | input | 1 | Receiver on; low forces hunt mode and clears flags |
| bit_en | input | 1 | Receive clock enable: one pulse per serial bit |
| rx_bit | input | 1 | Serial data bit, least significant first |
| sync_char | input | MAX_LEN | Sync character; only the low L bits are compared |
| word_len | input | 2 | Word length code, L = 5 + word_len |
| strip_en | input | 1 | Suppress framed words equal to the sync character |
| fs_wr | input | 1 | Host write strobe for the found bit |
| fs_wr_val | input | 1 | Value written to the found bit |
| found | output | 1 | 1 in framing mode, 0 while hunting |
| sync_irq | output | 1 | One-cycle pulse when the hunt finds the sync character |
| word_stb | output | 1 | One-cycle pulse for each framed word |
| word_sup | output | 1 | With word_stb: the buffer must not load this word |
| word_data | output | MAX_LEN | Last framed word, right aligned |
| match_flag | output | 1 | Last delivered word equalled the sync character |

## Verification
Two things can land on the same clock edge: a host write to the found bit, and the receive bit that would complete a match or a word. The bench drives fs_wr and bit_en together in two situations. The first is on the final bit of a word while framing, which must give no strobe and then need a full L more bits for the next word. The second is on the final bit of the sync pattern while hunting, where the write to 0 must win: no sync_irq, found stays 0, and the hunt needs L fresh bits. The same-edge overlap between a completed word and the strip and match decisions is also covered, by vectors that pair matching and non-matching words with strip_en on and off.

// File: rtl/sh_pkg.sv
package sh_pkg;
    typedef enum logic {
        SH_HUNT  = 1'b0,
        SH_FRAME = 1'b1
    } sh_mode_e;
endpackage

// File: rtl/sh_shift.sv
// Next window: new bit enters at position len-1, older bits move down,
// positions at or above len stay zero.
module sh_shift #(
    parameter int MAX_LEN = 8,
    parameter int LEN_W   = 4
) (
    input  logic [MAX_LEN-1:0] win_i,
    input  logic               bit_i,
    input  logic [LEN_W-1:0]   len_i,
    output logic [MAX_LEN-1:0] win_o
);
    for (genvar i = 0; i < MAX_LEN; i++) begin : g_pos
        if (i == MAX_LEN - 1) begin : g_top
            assign win_o[i] = (len_i == LEN_W'(i + 1)) ? bit_i : 1'b0;
        end else begin : g_low
            assign win_o[i] = (len_i == LEN_W'(i + 1)) ? bit_i
                            : ((len_i > LEN_W'(i + 1)) ? win_i[i+1] : 1'b0);
        end
    end
endmodule

// File: rtl/sh_cmp.sv
// Masked equality of the window against the low len bits of the sync char.
module sh_cmp #(
    parameter int MAX_LEN = 8,
    parameter int LEN_W   = 4
) (
    input  logic [MAX_LEN-1:0] win_i,
    input  logic [MAX_LEN-1:0] ref_i,
    input  logic [LEN_W-1:0]   len_i,
    output logic               hit_o
);
    logic [MAX_LEN-1:0] mask;
    for (genvar i = 0; i < MAX_LEN; i++) begin : g_mask
        assign mask[i] = (len_i > LEN_W'(i));
    end
    assign hit_o = ~|((win_i ^ ref_i) & mask);
endmodule

// File: rtl/sh_cnt.sv
// Bit counter step: incremented value and whether it reaches the length.
module sh_cnt #(
    parameter int LEN_W = 4
) (
    input  logic [LEN_W-1:0] cnt_i,
    input  logic [LEN_W-1:0] len_i,
    output logic [LEN_W-1:0] inc_o,
    output logic             at_len_o
);
    assign inc_o    = cnt_i + LEN_W'(1);
    assign at_len_o = (inc_o >= len_i);
endmodule

// File: rtl/sync_hunter.sv
module sync_hunter #(
    parameter int MAX_LEN = 8,
    parameter int MIN_LEN = 5
) (
    input  logic                                        clk,
    input  logic                                        rst_n,
    input  logic                                        rx_enable,
    input  logic                                        bit_en,
    input  logic                                        rx_bit,
    input  logic [MAX_LEN-1:0]                          sync_char,
    input  logic [$clog2(MAX_LEN-MIN_LEN+1)-1:0]        word_len,
    input  logic                                        strip_en,
    input  logic                                        fs_wr,
    input  logic                                        fs_wr_val,
    output logic                                        found,
    output logic                                        sync_irq,
    output logic                                        word_stb,
    output logic                                        word_sup,
    output logic [MAX_LEN-1:0]                          word_data,
    output logic                                        match_flag
);
    import sh_pkg::*;

    localparam int SEL_W = $clog2(MAX_LEN - MIN_LEN + 1);
    localparam int LEN_W = $clog2(MAX_LEN + 1);

    typedef struct packed {
        sh_mode_e           mode;
        logic [LEN_W-1:0]   cnt;
        logic [MAX_LEN-1:0] win;
        logic               irq;
        logic               stb;
        logic               sup;
        logic [MAX_LEN-1:0] data;
        logic               mflag;
    } sh_state_t;

    sh_state_t          st_d, st_q;
    logic [LEN_W-1:0]   len;
    logic [MAX_LEN-1:0] win_nx;
    logic               hit;
    logic [LEN_W-1:0]   cnt_inc;
    logic               at_len;

    assign len = LEN_W'(MIN_LEN) + LEN_W'(word_len);

    sh_shift #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_shift (
        .win_i (st_q.win),
        .bit_i (rx_bit),
        .len_i (len),
        .win_o (win_nx)
    );

    sh_cmp #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_cmp (
        .win_i (win_nx),
        .ref_i (sync_char),
        .len_i (len),
        .hit_o (hit)
    );

    sh_cnt #(.LEN_W(LEN_W)) u_cnt (
        .cnt_i    (st_q.cnt),
        .len_i    (len),
        .inc_o    (cnt_inc),
        .at_len_o (at_len)
    );

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        st_d.stb = 1'b0;
        st_d.sup = 1'b0;
        if (!rx_enable) begin
            st_d.mode  = SH_HUNT;
            st_d.cnt   = '0;
            st_d.win   = '0;
            st_d.mflag = 1'b0;
        end else if (fs_wr) begin
            // host write wins over a same-cycle bit
            st_d.mode = fs_wr_val ? SH_FRAME : SH_HUNT;
            st_d.cnt  = '0;
            st_d.win  = '0;
        end else if (bit_en) begin
            st_d.win = win_nx;
            if (st_q.mode == SH_HUNT) begin
                // count fills up to len, then saturates
                st_d.cnt = at_len ? len : cnt_inc;
                if (at_len && hit) begin
                    st_d.mode = SH_FRAME;
                    st_d.irq  = 1'b1;
                    st_d.cnt  = '0;
                end
            end else if (at_len) begin
                st_d.stb  = 1'b1;
                st_d.data = win_nx;
                st_d.sup  = strip_en && hit;
                st_d.cnt  = '0;
                if (!(strip_en && hit)) begin
                    st_d.mflag = hit;
                end
            end else begin
                st_d.cnt = cnt_inc;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign found      = (st_q.mode == SH_FRAME);
    assign sync_irq   = st_q.irq;
    assign word_stb   = st_q.stb;
    assign word_sup   = st_q.sup;
    assign word_data  = st_q.data;
    assign match_flag = st_q.mflag;

endmodule

// File: rtl/sh_hunter_chk.sv
module sh_hunter_chk (
    input logic clk,
    input logic rst_n,
    input logic rx_enable,
    input logic fs_wr,
    input logic fs_wr_val,
    input logic found,
    input logic sync_irq,
    input logic word_stb,
    input logic word_sup,
    input logic match_flag
);
    // R2: interrupt only on the hunt-to-frame transition
    a_r2_irq_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
        sync_irq |-> (found && !$past(found)));

    // R4: the hunt-ending word is never strobed
    a_r4_no_word_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
        sync_irq |-> !word_stb);

    // R5: words are only framed in framing mode
    a_r5_stb_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        word_stb |-> (found && $past(found)));

    // R6: match flag moves only on a delivered word or disable
    a_r6_flag_stable: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rx_enable) && !(word_stb && !word_sup)) |-> $stable(match_flag));

    // R7: suppress never appears on its own
    a_r7_sup_with_stb: assert property (@(posedge clk) disable iff (!rst_n)
        word_sup |-> word_stb);

    // R8: writing 0 to found returns to hunting
    a_r8_write_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_enable && fs_wr && !fs_wr_val) |=> !found);

    // R9: disable clears state and silences pulses
    a_r9_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_enable |=> (!found && !match_flag && !word_stb && !sync_irq));
endmodule

bind sync_hunter sh_hunter_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_enable  (rx_enable),
    .fs_wr      (fs_wr),
    .fs_wr_val  (fs_wr_val),
    .found      (found),
    .sync_irq   (sync_irq),
    .word_stb   (word_stb),
    .word_sup   (word_sup),
    .match_flag (match_flag)
);

// File: tb/sim_sync_hunter.sv
module sim_sync_hunter;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_enable = 1'b0;
    logic       bit_en = 1'b0;
    logic       rx_bit = 1'b0;
    logic [7:0] sync_char = 8'h00;
    logic [1:0] word_len = 2'd0;
    logic       strip_en = 1'b0;
    logic       fs_wr = 1'b0;
    logic       fs_wr_val = 1'b0;
    logic       found, sync_irq, word_stb, word_sup, match_flag;
    logic [7:0] word_data;

    int checks = 0;
    int errors = 0;
    logic exp_flag = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    sync_hunter u0 (
        .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .bit_en(bit_en),
        .rx_bit(rx_bit), .sync_char(sync_char), .word_len(word_len),
        .strip_en(strip_en), .fs_wr(fs_wr), .fs_wr_val(fs_wr_val),
        .found(found), .sync_irq(sync_irq), .word_stb(word_stb),
        .word_sup(word_sup), .word_data(word_data), .match_flag(match_flag)
    );

    typedef struct packed {
        logic [1:0] sel;
        logic [7:0] sync;
        logic       strip;
        logic [7:0] noise;
        logic [3:0] noise_n;
        logic [7:0] w1;
        logic [7:0] w2;
    } vec_t;

    localparam int NVEC = 5;
    localparam vec_t VECS [NVEC] = '{
        '{2'd3, 8'h16, 1'b0, 8'h07, 4'd3, 8'hA5, 8'h16},
        '{2'd3, 8'h16, 1'b1, 8'h07, 4'd3, 8'h16, 8'h3C},
        '{2'd0, 8'hF6, 1'b0, 8'h00, 4'd2, 8'h16, 8'h09},
        '{2'd1, 8'h2B, 1'b1, 8'h00, 4'd1, 8'h2B, 8'h2B},
        '{2'd2, 8'h7F, 1'b0, 8'h00, 4'd2, 8'h7F, 8'h00}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one bit on bit_en, rx_bit toggled while bit_en is low (R11)
    task automatic send_bit(input logic b);
        @(negedge clk); rx_bit = b; bit_en = 1'b1;
        @(negedge clk); bit_en = 1'b0; rx_bit = ~b;
    endtask

    task automatic restart();
        @(negedge clk); rx_enable = 1'b0;
        @(negedge clk); rx_enable = 1'b1;
        exp_flag = 1'b0;
    endtask

    task automatic write_fs(input logic val, input logic with_bit, input logic b);
        @(negedge clk); fs_wr = 1'b1; fs_wr_val = val;
        if (with_bit) begin bit_en = 1'b1; rx_bit = b; end
        @(negedge clk); fs_wr = 1'b0; bit_en = 1'b0;
    endtask

    initial begin
        #(CLK_P * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 found", found, 0);
        check("R1 irq", sync_irq, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 stb", word_stb, 0);
        check("R1 sup", word_sup, 0);
        check("R1 flag", match_flag, 0);

        // table walk: noise, sync, two framed words
        for (int v = 0; v < NVEC; v++) begin
            int   len;
            int   mask;
            logic m;
            logic [7:0] w;
            len = 5 + int'(VECS[v].sel);
            mask = (1 << len) - 1;
            word_len = VECS[v].sel;
            sync_char = VECS[v].sync;
            strip_en = VECS[v].strip;
            restart();
            for (int i = 0; i < int'(VECS[v].noise_n); i++) begin
                send_bit(VECS[v].noise[i]);
                check("R3 hunt on noise", found, 0);
                check("R3 no word in hunt", word_stb, 0);
            end
            for (int i = 0; i < len; i++) begin
                send_bit(VECS[v].sync[i]);
                check("R4 no strobe for sync", word_stb, 0);
                check("R2 found", found, (i == len - 1) ? 1 : 0);
                check("R2 irq", sync_irq, (i == len - 1) ? 1 : 0);
            end
            for (int k = 0; k < 2; k++) begin
                w = (k == 0) ? VECS[v].w1 : VECS[v].w2;
                m = ((int'(w) & mask) == (int'(VECS[v].sync) & mask));
                for (int j = 0; j < len; j++) begin
                    send_bit(w[j]);
                    if (j < len - 1) begin
                        check("R5 no early strobe", word_stb, 0);
                    end else begin
                        check("R5 strobe", word_stb, 1);
                        check("R5 data", word_data, int'(w) & mask);
                        check("R7 suppress", word_sup, VECS[v].strip && m);
                        if (!(VECS[v].strip && m)) exp_flag = m;
                        check("R6 match flag", match_flag, exp_flag);
                    end
                end
            end
        end

        // R8 host set, then R9 disable
        word_len = 2'd3; sync_char = 8'h16; strip_en = 1'b0;
        restart();
        write_fs(1'b1, 1'b0, 1'b0);
        check("R8 write set", found, 1);
        for (int j = 0; j < 8; j++) send_bit(sync_char[j]);
        check("R5 word after write", word_stb, 1);
        check("R6 flag set", match_flag, 1);
        @(negedge clk); rx_enable = 1'b0;
        @(negedge clk);
        check("R9 found cleared", found, 0);
        check("R9 flag cleared", match_flag, 0);
        for (int j = 0; j < 8; j++) begin
            send_bit(sync_char[j]);
            check("R9 ignored found", found, 0);
            check("R9 ignored irq", sync_irq, 0);
        end
        rx_enable = 1'b1;
        for (int j = 0; j < 8; j++) begin
            send_bit(sync_char[j]);
            check("R9 fresh hunt", found, (j == 7) ? 1 : 0);
        end

        // R10 all-zero sync needs a full window
        word_len = 2'd0; sync_char = 8'h00;
        restart();
        for (int j = 0; j < 5; j++) begin
            send_bit(1'b0);
            check("R10 fill", found, (j == 4) ? 1 : 0);
        end

        // R8 clear returns to hunting with empty window
        write_fs(1'b0, 1'b0, 1'b0);
        check("R8 write clear", found, 0);
        for (int j = 0; j < 5; j++) begin
            send_bit(1'b0);
            check("R8 rehunt", found, (j == 4) ? 1 : 0);
        end

        // R8 write on the final bit of a word drops that bit
        for (int j = 0; j < 4; j++) send_bit(1'b1);
        write_fs(1'b1, 1'b1, 1'b1);
        check("R8 same-cycle no strobe", word_stb, 0);
        check("R8 same-cycle found", found, 1);
        for (int j = 0; j < 5; j++) begin
            send_bit(1'b1);
            check("R8 restart count", word_stb, (j == 4) ? 1 : 0);
        end
        check("R5 data ones", word_data, 8'h1F);

        // R8 write 0 on the bit that would end the hunt
        write_fs(1'b0, 1'b0, 1'b0);
        for (int j = 0; j < 4; j++) send_bit(1'b0);
        write_fs(1'b0, 1'b1, 1'b0);
        check("R8 write beats match found", found, 0);
        check("R8 write beats match irq", sync_irq, 0);
        for (int j = 0; j < 5; j++) begin
            send_bit(1'b0);
            check("R8 hunt after conflict", found, (j == 4) ? 1 : 0);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule